// File: doc/BRIEF.md
# Mode-Dependent GPIO Port Controller

An eight-pin general-purpose I/O port controlled through a small memory-mapped register set: a write-only direction register, a read/write output data register and a read-only register that returns the live pin levels. Each pin drives its data bit when its direction bit is 1 and is an input when the bit is 0. An operating-mode input decides who owns each pin. In single-chip mode (mode 7) all eight pins are ordinary I/O. In any other mode the port sits beside an external bus: pins 6 to 3 are taken over by bus-control strobes, which arrive as inputs, and pin 7 carries the system clock whenever its direction bit is set.

Reset handling follows the kind of event. Power-on reset and hardware standby restore the direction register to a value that depends on the mode. A manual reset clears only the data register. Software standby freezes both registers, and a hold select decides whether the bus-driven pins keep their last level or float.

All resets, standby inputs and register writes take effect at the rising clock edge. Register reads and the pin outputs are combinational.

Top module: `gpio_port_ctl`

## Requirements
- R1: A write to address 0xFE3E loads the direction register at the next clock edge. A read of 0xFE3E returns 0x00. Bit n of the register is 1 for output on pin n.
- R2: The data register at 0xFF0E is written at the clock edge and reads back the last value written.
- R3: A read of 0xFFBE returns pad_in. A write to 0xFFBE changes neither register.
- R4: While por_n is low or hw_stby is high, at each clock edge the direction register loads 0x80 when mode is not 7 and 0x00 when mode is 7, and the data register loads 0x00.
- R5: man_rst clears the data register to 0x00 and leaves the direction register unchanged.
- R6: In mode 7, pad_oe equals the direction register and pad_out equals the data register on all eight pins.
- R7: In any mode other than 7, pin 7 drives clk_src with its enable set when direction bit 7 is 1. When that bit is 0, pin 7 is an input.
- R8: In any mode other than 7, pins 6 to 3 are enabled whatever their direction bits. Pin 6 carries as_n, pin 5 rd_n, pin 4 hwr_n and pin 3 lwr_n. When cas_sel is 1, pin 6 carries cas_n in place of as_n.
- R9: Pins 2 to 0 follow the direction and data registers in every mode.
- R10: With sw_stby high and stby_hold 1, the bus-driven pins stay enabled and keep the level they had at the last clock edge before standby.
- R11: With sw_stby high and stby_hold 0, the bus-driven pins have their output enables cleared.
- R12: While sw_stby is high, bus writes are ignored and both registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| man_rst | input | 1 | Manual reset, active high, synchronous |
| hw_stby | input | 1 | Hardware standby request, active high |
| sw_stby | input | 1 | Software standby request, active high |
| stby_hold | input | 1 | 1 keeps bus-driven pins at their last level in software standby; 0 floats them |
| mode | input | 3 | Operating mode; 7 is single-chip, any other value is an external-bus mode |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register address, low 16 bits |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when not reading |
| clk_src | input | 1 | System clock level for pin 7 |
| as_n | input | 1 | Address strobe from the bus controller |
| rd_n | input | 1 | Read strobe |
| hwr_n | input | 1 | High-byte write strobe |
| lwr_n | input | 1 | Low-byte write strobe |
| cas_n | input | 1 | Column-address strobe |
| cas_sel | input | 1 | Routes cas_n to pin 6 in place of as_n |
| pad_in | input | 8 | Live pin levels |
| pad_out | output | 8 | Pin output levels |
| pad_oe | output | 8 | Pin output enables |

## Verification
The bound checker checks the following on every cycle. It checks that the strobe pins carry their strobes while not in standby and that single-chip mode mirrors the direction register onto the enables. It checks that a pin-state read returns the pads and that a direction read returns zero. It checks that software standby either floats the bus pins or freezes them, and that a manual reset leaves the direction register alone. Only the bench scenarios can show end-to-end effects that span several events. These are the mode-dependent reload after hardware standby observed later in single-chip mode, a write to the pin-state address that leaves the data register untouched, and writes during standby that are lost once standby ends.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      SRC_GPIO = 2'd0,
      SRC_CLK  = 2'd1,
      SRC_STRB = 2'd2
   } pin_src_e;

   function automatic pin_src_e pin_kind(input int idx, input int clk_pin,
                                         input int strb_hi, input int strb_lo);
      if (idx == clk_pin) return SRC_CLK;
      if (idx <= strb_hi && idx >= strb_lo) return SRC_STRB;
      return SRC_GPIO;
   endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8,
   parameter logic [ADDR_W-1:0] DIR_A  = 16'hFE3E,
   parameter logic [ADDR_W-1:0] DATA_A = 16'hFF0E,
   parameter logic [ADDR_W-1:0] PIN_A  = 16'hFFBE,
   parameter logic [MODE_W-1:0] SC_MODE = 3'd7,
   parameter logic [PORT_W-1:0] DIR_BUS_RST = 8'h80
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              man_rst,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic [MODE_W-1:0] mode,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PORT_W-1:0] bus_wdata,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] bus_rdata,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] data_q
);
   logic full_rst;
   logic wr_ok;
   assign full_rst = !por_n || hw_stby;
   assign wr_ok    = bus_we && !sw_stby;

   always_ff @(posedge clk) begin
      if (full_rst)
         dir_q <= (mode == SC_MODE) ? '0 : DIR_BUS_RST;
      else if (wr_ok && bus_addr == DIR_A)
         dir_q <= bus_wdata;
   end

   always_ff @(posedge clk) begin
      if (full_rst || man_rst)
         data_q <= '0;
      else if (wr_ok && bus_addr == DATA_A)
         data_q <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (bus_addr == DATA_A)     bus_rdata = data_q;
         else if (bus_addr == PIN_A) bus_rdata = pad_in;
      end
   end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
   import gpio_port_pkg::*;
#(
   parameter int PORT_W  = 8,
   parameter int CLK_PIN = 7,
   parameter int STRB_HI = 6,
   parameter int STRB_LO = 3
) (
   input  logic              bus_mode,
   input  logic [PORT_W-1:0] dir_q,
   input  logic [PORT_W-1:0] data_q,
   input  logic              clk_src,
   input  logic [STRB_HI:STRB_LO] strobes,
   output logic [PORT_W-1:0] bus_sel,
   output logic [PORT_W-1:0] func_out,
   output logic [PORT_W-1:0] func_oe
);
   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      localparam pin_src_e KIND = pin_kind(i, CLK_PIN, STRB_HI, STRB_LO);
      logic sel;
      logic val;
      if (KIND == SRC_CLK) begin : g_clk
         assign sel = bus_mode && dir_q[i];
         assign val = clk_src;
      end else if (KIND == SRC_STRB) begin : g_strb
         assign sel = bus_mode;
         assign val = strobes[i];
      end else begin : g_gpio
         assign sel = 1'b0;
         assign val = 1'b0;
      end
      assign bus_sel[i]  = sel;
      assign func_out[i] = sel ? val  : data_q[i];
      assign func_oe[i]  = sel ? 1'b1 : dir_q[i];
   end
endmodule

// File: rtl/gpio_port_stby.sv
module gpio_port_stby
   import gpio_port_pkg::*;
#(
   parameter int PORT_W  = 8,
   parameter int CLK_PIN = 7,
   parameter int STRB_HI = 6,
   parameter int STRB_LO = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sw_stby,
   input  logic              stby_hold,
   input  logic [PORT_W-1:0] bus_sel,
   input  logic [PORT_W-1:0] func_out,
   input  logic [PORT_W-1:0] func_oe,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe
);
   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      localparam pin_src_e KIND = pin_kind(i, CLK_PIN, STRB_HI, STRB_LO);
      if (KIND == SRC_GPIO) begin : g_pass
         assign pad_out[i] = func_out[i];
         assign pad_oe[i]  = func_oe[i];
      end else begin : g_hold
         logic held_q;
         logic frozen;
         always_ff @(posedge clk) begin
            if (!por_n)        held_q <= 1'b0;
            else if (!sw_stby) held_q <= func_out[i];
         end
         assign frozen     = sw_stby && bus_sel[i];
         assign pad_out[i] = frozen ? held_q : func_out[i];
         assign pad_oe[i]  = frozen ? stby_hold : func_oe[i];
      end
   end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int PORT_W  = 8,
   parameter int CLK_PIN = 7,
   parameter int STRB_HI = 6,
   parameter int STRB_LO = 3,
   parameter logic [ADDR_W-1:0] DIR_A  = 16'hFE3E,
   parameter logic [ADDR_W-1:0] DATA_A = 16'hFF0E,
   parameter logic [ADDR_W-1:0] PIN_A  = 16'hFFBE,
   parameter logic [MODE_W-1:0] SC_MODE = 3'd7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              man_rst,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic              stby_hold,
   input  logic [MODE_W-1:0] mode,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic              clk_src,
   input  logic              as_n,
   input  logic              rd_n,
   input  logic              hwr_n,
   input  logic              lwr_n,
   input  logic              cas_n,
   input  logic              cas_sel,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe
);
   localparam logic [PORT_W-1:0] DIR_BUS_RST = PORT_W'(1) << CLK_PIN;
   localparam int STRB_N = STRB_HI - STRB_LO + 1;

   if (STRB_N != 4) begin : g_bad_strb
      $error("strobe field must span four pins");
   end
   if (CLK_PIN >= PORT_W || STRB_HI >= PORT_W || STRB_LO < 0) begin : g_bad_pin
      $error("pin index outside the port");
   end
   if (CLK_PIN <= STRB_HI && CLK_PIN >= STRB_LO) begin : g_bad_ovl
      $error("clock pin overlaps strobe field");
   end

   logic [PORT_W-1:0] dir_q, data_q, bus_sel, func_out, func_oe;
   logic [STRB_HI:STRB_LO] strobes;
   logic bus_mode;

   assign bus_mode = (mode != SC_MODE);
   assign strobes  = {cas_sel ? cas_n : as_n, rd_n, hwr_n, lwr_n};

   gpio_port_regs #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DIR_A(DIR_A), .DATA_A(DATA_A),
      .PIN_A(PIN_A), .SC_MODE(SC_MODE), .DIR_BUS_RST(DIR_BUS_RST)
   ) regs_i (
      .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
      .sw_stby(sw_stby), .mode(mode), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_in(pad_in),
      .bus_rdata(bus_rdata), .dir_q(dir_q), .data_q(data_q)
   );

   gpio_port_mux #(
      .PORT_W(PORT_W), .CLK_PIN(CLK_PIN), .STRB_HI(STRB_HI), .STRB_LO(STRB_LO)
   ) mux_i (
      .bus_mode(bus_mode), .dir_q(dir_q), .data_q(data_q), .clk_src(clk_src),
      .strobes(strobes), .bus_sel(bus_sel), .func_out(func_out), .func_oe(func_oe)
   );

   gpio_port_stby #(
      .PORT_W(PORT_W), .CLK_PIN(CLK_PIN), .STRB_HI(STRB_HI), .STRB_LO(STRB_LO)
   ) stby_i (
      .clk(clk), .por_n(por_n), .sw_stby(sw_stby), .stby_hold(stby_hold),
      .bus_sel(bus_sel), .func_out(func_out), .func_oe(func_oe),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int PORT_W  = 8,
   parameter int STRB_HI = 6,
   parameter int STRB_LO = 3,
   parameter logic [ADDR_W-1:0] DIR_A = 16'hFE3E,
   parameter logic [ADDR_W-1:0] PIN_A = 16'hFFBE,
   parameter logic [MODE_W-1:0] SC_MODE = 3'd7
) (
   input logic              clk,
   input logic              por_n,
   input logic              man_rst,
   input logic              hw_stby,
   input logic              sw_stby,
   input logic              stby_hold,
   input logic [MODE_W-1:0] mode,
   input logic              bus_re,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [PORT_W-1:0] bus_rdata,
   input logic              rd_n,
   input logic              hwr_n,
   input logic              lwr_n,
   input logic [PORT_W-1:0] pad_in,
   input logic [PORT_W-1:0] pad_out,
   input logic [PORT_W-1:0] pad_oe,
   input logic [PORT_W-1:0] dir_q
);
   // R1
   dir_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (bus_re && bus_addr == DIR_A) |-> bus_rdata == '0);

   // R3
   pin_read_chk: assert property (@(posedge clk) disable iff (!por_n)
      (bus_re && bus_addr == PIN_A) |-> bus_rdata == pad_in);

   // R5
   man_rst_keeps_dir_chk: assert property (@(posedge clk) disable iff (!por_n)
      (man_rst && !hw_stby) |=> dir_q == $past(dir_q));

   // R6
   single_chip_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == SC_MODE) |-> pad_oe == dir_q);

   // R8
   strobe_pins_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode != SC_MODE && !sw_stby) |->
         (&pad_oe[STRB_HI:STRB_LO]) && pad_out[STRB_HI-1] == rd_n &&
         pad_out[STRB_HI-2] == hwr_n && pad_out[STRB_LO] == lwr_n);

   // R10
   stby_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sw_stby && stby_hold && mode != SC_MODE && $past(sw_stby) &&
       $past(mode) == mode && $past(por_n)) |->
         $stable(pad_out[STRB_HI:STRB_LO]));

   // R11
   stby_float_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sw_stby && !stby_hold && mode != SC_MODE) |->
         pad_oe[STRB_HI:STRB_LO] == '0);
endmodule

bind gpio_port_ctl gpio_port_chk #(
   .ADDR_W(ADDR_W), .PORT_W(PORT_W), .STRB_HI(STRB_HI), .STRB_LO(STRB_LO),
   .DIR_A(DIR_A), .PIN_A(PIN_A), .SC_MODE(SC_MODE)
) chk_i (
   .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
   .sw_stby(sw_stby), .stby_hold(stby_hold), .mode(mode), .bus_re(bus_re),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rd_n(rd_n), .hwr_n(hwr_n),
   .lwr_n(lwr_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
   .dir_q(dir_q)
);

// File: tb/gpio_port_ctl_tb_top.sv
module gpio_port_ctl_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por_n, man_rst, hw_stby, sw_stby, stby_hold;
   logic [2:0] mode;
   logic bus_we, bus_re;
   logic [15:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;
   logic clk_src, as_n, rd_n, hwr_n, lwr_n, cas_n, cas_sel;
   logic [7:0] pad_in, pad_out, pad_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [15:0] A_DIR = 16'hFE3E;
   localparam logic [15:0] A_DAT = 16'hFF0E;
   localparam logic [15:0] A_PIN = 16'hFFBE;

   gpio_port_ctl dut_i (
      .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
      .sw_stby(sw_stby), .stby_hold(stby_hold), .mode(mode), .bus_we(bus_we),
      .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .clk_src(clk_src), .as_n(as_n), .rd_n(rd_n),
      .hwr_n(hwr_n), .lwr_n(lwr_n), .cas_n(cas_n), .cas_sel(cas_sel),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   typedef struct packed {
      logic [2:0] md;
      logic [7:0] dir;
      logic [7:0] dat;
      logic [7:0] pin;
      logic [7:0] exp_out;
      logic [7:0] exp_oe;
   } vec_t;

   // Strobes held at as=1 rd=0 hwr=1 lwr=0, clk_src=1 during the table.
   localparam vec_t VT [6] = '{
      '{3'd7, 8'hFF, 8'hA5, 8'h96, 8'hA5, 8'hFF},
      '{3'd7, 8'h0F, 8'h3C, 8'h3C, 8'h3C, 8'h0F},
      '{3'd4, 8'h00, 8'hFF, 8'h01, 8'hD7, 8'h78},
      '{3'd5, 8'h80, 8'h00, 8'hF0, 8'hD0, 8'hF8},
      '{3'd6, 8'h05, 8'h02, 8'h5A, 8'h52, 8'h7D},
      '{3'd7, 8'h55, 8'h00, 8'hC3, 8'h00, 8'h55}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #1 d = bus_rdata;
      bus_re = 1'b0;
   endtask

   task automatic do_por(input logic [2:0] m);
      @(negedge clk);
      mode = m; por_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      por_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      por_n = 1'b0; man_rst = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0;
      stby_hold = 1'b1; mode = 3'd4; bus_we = 1'b0; bus_re = 1'b0;
      bus_addr = '0; bus_wdata = '0; clk_src = 1'b1; as_n = 1'b1;
      rd_n = 1'b0; hwr_n = 1'b1; lwr_n = 1'b0; cas_n = 1'b0; cas_sel = 1'b0;
      pad_in = 8'h00;

      // R4: power-on in a bus mode gives dir 0x80, so enables 0xF8
      do_por(3'd4);
      @(negedge clk); #1;
      check("R4 por bus-mode oe", pad_oe, 8'hF8);
      rd(A_DAT, r);
      check("R4 por data", r, 8'h00);
      do_por(3'd7);
      @(negedge clk); #1;
      check("R4 por single-chip oe", pad_oe, 8'h00);

      // Table: R2 R3 R6 R7 R8 R9
      foreach (VT[k]) begin
         mode = VT[k].md;
         wr(A_DIR, VT[k].dir);
         wr(A_DAT, VT[k].dat);
         pad_in = VT[k].pin;
         @(negedge clk); #1;
         check("R6/R7/R8/R9 pad_out", pad_out, VT[k].exp_out);
         check("R6/R7/R8/R9 pad_oe", pad_oe, VT[k].exp_oe);
         rd(A_DAT, r);
         check("R2 data readback", r, VT[k].dat);
         rd(A_PIN, r);
         check("R3 pin read", r, VT[k].pin);
      end

      // R1: direction read is zero
      rd(A_DIR, r);
      check("R1 dir read", r, 8'h00);

      // R3: write to pin-state address touches nothing
      mode = 3'd7;
      wr(A_DIR, 8'h0F);
      wr(A_DAT, 8'hAA);
      wr(A_PIN, 8'h77);
      rd(A_DAT, r);
      check("R3 pin write data kept", r, 8'hAA);
      check("R3 pin write dir kept", pad_oe, 8'h0F);

      // R5: manual reset clears data, keeps direction
      @(negedge clk); man_rst = 1'b1;
      @(negedge clk); man_rst = 1'b0;
      rd(A_DAT, r);
      check("R5 man_rst data", r, 8'h00);
      check("R5 man_rst dir", pad_oe, 8'h0F);

      // R4: hardware standby in mode 5 reloads dir 0x80, seen in mode 7
      @(negedge clk); mode = 3'd5; hw_stby = 1'b1;
      @(negedge clk); hw_stby = 1'b0; mode = 3'd7;
      #1 check("R4 hw standby dir", pad_oe, 8'h80);

      // R8: column-address strobe on pin 6
      mode = 3'd4; cas_sel = 1'b1; cas_n = 1'b0;
      #1 check("R8 cas on pin6", {7'd0, pad_out[6]}, 8'h00);
      cas_sel = 1'b0;
      #1 check("R8 as on pin6", {7'd0, pad_out[6]}, 8'h01);

      // R10: hold in software standby
      wr(A_DIR, 8'h80);
      stby_hold = 1'b1;
      @(negedge clk); sw_stby = 1'b1;
      as_n = 1'b0; rd_n = 1'b1; hwr_n = 1'b0; lwr_n = 1'b1; clk_src = 1'b0;
      @(negedge clk); #1;
      check("R10 held levels", pad_out & 8'hF8, 8'hD0);
      check("R10 held enables", pad_oe & 8'hF8, 8'hF8);

      // R11: float in software standby
      stby_hold = 1'b0;
      #1 check("R11 float enables", pad_oe & 8'hF8, 8'h00);

      // R12: writes during standby are dropped
      wr(A_DAT, 8'h33);
      wr(A_DIR, 8'h07);
      @(negedge clk); sw_stby = 1'b0; mode = 3'd7;
      rd(A_DAT, r);
      check("R12 data kept", r, 8'h00);
      check("R12 dir kept", pad_oe, 8'h80);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule